// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches three 8-line GPIO ports, called A, B and F, and turns pin activity into interrupt requests. Each line can be set, one bit at a time, to react either to a level or to an edge. A second bit picks the active level or the edge direction. Every pin first passes through a two-flop synchronizer. It can then go through an optional debounce filter, which is clocked by a shared prescaler tick. After that the line reaches event detection. An edge event is held in a per-line latch until software acknowledges it. A level event follows the filtered pin directly.

Software reaches the block over a small memory-mapped bus with single-cycle accesses. Each port has six registers: mode, polarity, acknowledge, enable, status and debounce. All six sit at the same relative offsets from that port's base address. Ports A and B together drive one shared interrupt line. Port F drives one interrupt line for each of its eight pins, so a per-pin handler can be attached directly.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, no status bit is set, irq_ab is 0 and irq_f is 0.
- R2: With its mode bit at 1 (edge), a line whose polarity bit is 1 latches on a 0-to-1 transition of its filtered input, and a line whose polarity bit is 0 latches on a 1-to-0 transition. The opposite transition does not latch. Once set, the latch holds after the pin returns.
- R3: Writing the acknowledge register (relative offset 0x08) clears the latch of each line whose data bit is 1. Lines written with a 0 keep their latch.
- R4: A line whose enable bit (offset 0x0C) is 0 never shows status. Clearing the enable bit discards a pending latch, so setting the bit again does not bring back an event from before.
- R5: With its mode bit at 0 (level), a line's status equals its enable bit ANDed with (filtered pin equals polarity bit). This status is not latched.
- R6: With its debounce bit (offset 0x18) set, a new pin level is accepted only after it differs from the accepted level on DB_COUNT consecutive prescaler ticks, one tick every DB_PRESCALE cycles. A shorter pulse has no effect.
- R7: With debounce off, a pin change driven before clock edge k shows on a level-mode status at edge k+2, and not before.
- R8: irq_ab is the OR of all port A and port B status bits. irq_f bit i is the status of port F line i. Port F never affects irq_ab.
- R9: The mode (offset 0x00), polarity (0x04), enable (0x0C) and debounce (0x18) registers read back the last value written. Status (0x10) reads the current per-line status. Port bases are A 0x90, B 0xAC and F 0x4C.
- R10: The acknowledge register reads as 0, and a read of any address outside the map returns 0.
- R11: Changing a polarity bit never creates an edge event. Only a transition of the filtered input can set a latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Read data, valid in the same cycle as the strobe |
| gpio_a_in | input | LINES | Port A pin levels |
| gpio_b_in | input | LINES | Port B pin levels |
| gpio_f_in | input | LINES | Port F pin levels |
| irq_ab | output | 1 | Shared interrupt for ports A and B |
| irq_f | output | LINES | One interrupt per port F line |

## Verification
The embedded properties watch, on every cycle, a set of behaviours. They check that an edge latch only rises after a change of the filtered input. They check that an acknowledged line with no new edge is clear on the next cycle, and that a disabled line loses its latch. They check that a debounced line holds its level between prescaler ticks, and that the acknowledge register and unmapped addresses read as zero. Other behaviours can only be shown by the bench's scenarios: the exact synchronizer latency, the selection between rising and falling edges, the rejection of a short glitch by the debounce filter, and the routing of A and B onto the shared line while F stays on its own lines.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned NUM_PORTS = 3;

  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_POL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DEB  = 8'h18;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_MODE,
    FLD_POL,
    FLD_ACK,
    FLD_EN,
    FLD_STAT,
    FLD_DEB
  } reg_field_e;

  function automatic reg_field_e field_of(input logic [ADDR_W-1:0] addr,
                                          input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] rel;
    rel = addr - base;
    case (rel)
      OFS_MODE: field_of = FLD_MODE;
      OFS_POL:  field_of = FLD_POL;
      OFS_ACK:  field_of = FLD_ACK;
      OFS_EN:   field_of = FLD_EN;
      OFS_STAT: field_of = FLD_STAT;
      OFS_DEB:  field_of = FLD_DEB;
      default:  field_of = FLD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_rst_sync.sv
module gpio_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/gpio_irq_line_cond.sv
module gpio_irq_line_cond #(
  parameter int unsigned DB_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic deb_en,
  input  logic pin,
  output logic filt
);

  localparam int unsigned CW = (DB_COUNT > 1) ? $clog2(DB_COUNT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DB_COUNT - 1);

  logic          meta_q;
  logic          sync_q;
  logic          filt_q;
  logic          filt_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // next-state: bypass, or count consecutive differing ticks
  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (!deb_en) begin
      filt_d = sync_q;
      cnt_d  = '0;
    end else if (tick) begin
      if (sync_q != filt_q) begin
        if (cnt_q == CNT_LAST) begin
          filt_d = sync_q;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt = filt_q;

  // R6: a debounced line only moves on a tick
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_en && !tick) |=> $stable(filt_q));

  // R7: without debounce the filtered level trails the synchronizer by one edge
  a_r7_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !deb_en |=> (filt_q == $past(sync_q)));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE     = 8'h90,
  parameter int unsigned       LINES    = 8,
  parameter int unsigned       DB_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LINES-1:0]  pins,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic              rd_hit,
  output logic [LINES-1:0]  rd_data,
  output logic [LINES-1:0]  status
);

  reg_field_e       fld;
  logic             wr_go;
  logic             mode_we, pol_we, en_we, deb_we, ack_we;

  logic [LINES-1:0] mode_q, mode_d;
  logic [LINES-1:0] pol_q,  pol_d;
  logic [LINES-1:0] en_q,   en_d;
  logic [LINES-1:0] deb_q,  deb_d;
  logic [LINES-1:0] latch_q, latch_d;
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] filt;
  logic [LINES-1:0] edge_ev;
  logic [LINES-1:0] ack_clr;
  logic [LINES-1:0] level_hit;

  // per-line conditioning
  for (genvar i = 0; i < LINES; i++) begin : g_line
    gpio_irq_line_cond #(
      .DB_COUNT (DB_COUNT)
    ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .deb_en (deb_q[i]),
      .pin    (pins[i]),
      .filt   (filt[i])
    );
  end

  // address decode and write enables
  assign fld     = field_of(bus_addr, BASE);
  assign wr_go   = bus_en & bus_we;
  assign mode_we = wr_go & (fld == FLD_MODE);
  assign pol_we  = wr_go & (fld == FLD_POL);
  assign en_we   = wr_go & (fld == FLD_EN);
  assign deb_we  = wr_go & (fld == FLD_DEB);
  assign ack_we  = wr_go & (fld == FLD_ACK);

  // event detection: transition of the filtered level into the selected state
  assign edge_ev   = (filt ^ prev_q) & ~(filt ^ pol_q);
  assign level_hit = ~(filt ^ pol_q);
  assign ack_clr   = ack_we ? bus_wdata : '0;

  // next-state
  always_comb begin
    mode_d  = mode_we ? bus_wdata : mode_q;
    pol_d   = pol_we  ? bus_wdata : pol_q;
    en_d    = en_we   ? bus_wdata : en_q;
    deb_d   = deb_we  ? bus_wdata : deb_q;
    // a fresh edge wins over an acknowledge in the same cycle
    latch_d = en_q & mode_q & (edge_ev | (latch_q & ~ack_clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      deb_q   <= '0;
      latch_q <= '0;
      prev_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      pol_q   <= pol_d;
      en_q    <= en_d;
      deb_q   <= deb_d;
      latch_q <= latch_d;
      prev_q  <= filt;
    end
  end

  // status: latched for edge lines, live for level lines
  assign status = en_q & ((mode_q & latch_q) | (~mode_q & level_hit));

  // read path
  always_comb begin
    rd_hit  = bus_en & ~bus_we & (fld != FLD_NONE);
    rd_data = '0;
    if (rd_hit) begin
      case (fld)
        FLD_MODE: rd_data = mode_q;
        FLD_POL:  rd_data = pol_q;
        FLD_EN:   rd_data = en_q;
        FLD_STAT: rd_data = status;
        FLD_DEB:  rd_data = deb_q;
        default:  rd_data = '0;
      endcase
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    // R2 / R11: a latch can only rise after the filtered input changed
    a_r2_latch_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_q[i]) |-> $past(filt[i] != prev_q[i]));

    // R3: an acknowledged line with no new edge is clear next cycle
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && bus_wdata[i] && !edge_ev[i]) |=> !latch_q[i]);

    // R4: a disabled line holds no pending latch
    a_r4_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> !latch_q[i]);
  end

  // R9: mode register takes the written value
  a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == $past(bus_wdata)));

  // R10: acknowledge register reads as zero
  a_r10_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && fld == FLD_ACK) |-> (rd_data == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned       LINES       = 8,
  parameter int unsigned       DB_PRESCALE = 16,
  parameter int unsigned       DB_COUNT    = 4,
  parameter logic [ADDR_W-1:0] A_BASE      = 8'h90,
  parameter logic [ADDR_W-1:0] B_BASE      = 8'hAC,
  parameter logic [ADDR_W-1:0] F_BASE      = 8'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  gpio_a_in,
  input  logic [LINES-1:0]  gpio_b_in,
  input  logic [LINES-1:0]  gpio_f_in,
  output logic              irq_ab,
  output logic [LINES-1:0]  irq_f
);

  localparam int unsigned PW = (DB_PRESCALE > 1) ? $clog2(DB_PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_RELOAD = PW'(DB_PRESCALE - 1);
  localparam logic [ADDR_W-1:0] PORT_BASES [NUM_PORTS] = '{A_BASE, B_BASE, F_BASE};

  logic                 rst_sync_n;
  logic [PW-1:0]        pre_q, pre_d;
  logic                 tick;
  logic [LINES-1:0]     port_pins [NUM_PORTS];
  logic [LINES-1:0]     port_rd   [NUM_PORTS];
  logic [LINES-1:0]     port_stat [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_hit;

  gpio_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // shared sample-tick prescaler
  assign tick = (pre_q == '0);

  always_comb begin
    pre_d = tick ? PRE_RELOAD : (pre_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pre_q <= '0;
    else             pre_q <= pre_d;
  end

  assign port_pins[0] = gpio_a_in;
  assign port_pins[1] = gpio_b_in;
  assign port_pins[2] = gpio_f_in;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_irq_port #(
      .BASE     (PORT_BASES[p]),
      .LINES    (LINES),
      .DB_COUNT (DB_COUNT)
    ) u_port (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .tick      (tick),
      .pins      (port_pins[p]),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .rd_hit    (port_hit[p]),
      .rd_data   (port_rd[p]),
      .status    (port_stat[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) bus_rdata = bus_rdata | port_rd[p];
  end

  assign irq_ab = |(port_stat[0] | port_stat[1]);
  assign irq_f  = port_stat[2];

  // R10: reads outside the map return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_en && !bus_we && port_hit == '0) |-> (bus_rdata == '0));

  // R9: at most one port claims a read
  a_r9_single_claim: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(port_hit));

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

  localparam logic [7:0] BA = 8'h90, BB = 8'hAC, BF = 8'h4C;
  localparam logic [7:0] O_MODE = 8'h00, O_POL = 8'h04, O_ACK = 8'h08,
                         O_EN = 8'h0C, O_STAT = 8'h10, O_DEB = 8'h18;
  localparam int K_RD = 0, K_AB = 1, K_F = 2;

  logic       clk;
  logic       rst_n;
  logic       bus_en, bus_we;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [7:0] pa, pb, pf;
  logic       irq_ab;
  logic [7:0] irq_f;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    checks;
  int    errors;
  bit    done;

  gpio_irq_ctrl #(
    .DB_PRESCALE (4),
    .DB_COUNT    (4)
  ) u_gpio_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_a_in (pa),
    .gpio_b_in (pb),
    .gpio_f_in (pf),
    .irq_ab    (irq_ab),
    .irq_f     (irq_f)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = bus_rdata;
          K_AB:    act = {7'b0, irq_ab};
          default: act = irq_f;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    q.push_back('{K_RD, e, tag});
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic out_chk(input int kind, input logic [7:0] e, input string tag);
    @(negedge clk);
    q.push_back('{kind, e, tag});
  endtask

  task automatic set_pins(input int port, input logic [7:0] v);
    @(negedge clk);
    case (port)
      0: pa = v;
      1: pb = v;
      default: pf = v;
    endcase
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    pa = '0; pb = '0; pf = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    rd_chk(BA + O_MODE, 8'h00, "R1 A mode after reset");
    rd_chk(BB + O_EN,   8'h00, "R1 B enable after reset");
    rd_chk(BF + O_DEB,  8'h00, "R1 F debounce after reset");
    rd_chk(BF + O_STAT, 8'h00, "R1 F status after reset");
    out_chk(K_AB, 8'h00, "R1 irq_ab after reset");
    out_chk(K_F,  8'h00, "R1 irq_f after reset");

    // R9 / R10: map and readback
    wr(BA + O_MODE, 8'hA5);
    rd_chk(BA + O_MODE, 8'hA5, "R9 A mode readback");
    wr(BB + O_POL, 8'h3C);
    rd_chk(BB + O_POL, 8'h3C, "R9 B polarity readback");
    wr(BF + O_DEB, 8'h81);
    rd_chk(BF + O_DEB, 8'h81, "R9 F debounce readback");
    wr(BA + O_ACK, 8'hFF);
    rd_chk(BA + O_ACK, 8'h00, "R10 acknowledge reads zero");
    rd_chk(8'h00, 8'h00, "R10 unmapped 0x00");
    rd_chk(8'h91, 8'h00, "R10 unmapped 0x91");
    rd_chk(8'hA4, 8'h00, "R10 unmapped 0xA4");
    wr(BA + O_MODE, 8'h00);
    wr(BB + O_POL, 8'h00);
    wr(BF + O_DEB, 8'h00);

    // R5 / R7: level mode on port A line 0
    wr(BA + O_POL, 8'h01);
    wr(BA + O_EN,  8'h01);
    out_chk(K_AB, 8'h00, "R5 level high, pin low");
    set_pins(0, 8'h01);
    idle(1);
    out_chk(K_AB, 8'h00, "R7 not visible after two edges");
    out_chk(K_AB, 8'h01, "R7 visible after third edge");
    rd_chk(BA + O_STAT, 8'h01, "R9 A status reads line 0");
    set_pins(0, 8'h00);
    idle(4);
    out_chk(K_AB, 8'h00, "R5 level status not latched");
    wr(BA + O_POL, 8'h00);
    out_chk(K_AB, 8'h01, "R5 active-low match");
    wr(BA + O_EN, 8'h00);
    out_chk(K_AB, 8'h00, "R4 disabled level line quiet");

    // R2 / R3 / R11: edge mode on port B line 3
    wr(BB + O_MODE, 8'h08);
    wr(BB + O_POL,  8'h08);
    wr(BB + O_EN,   8'h08);
    out_chk(K_AB, 8'h00, "R2 no event before edge");
    set_pins(1, 8'h08);
    idle(4);
    out_chk(K_AB, 8'h01, "R2 rising edge latched");
    rd_chk(BB + O_STAT, 8'h08, "R2 B status bit 3");
    set_pins(1, 8'h00);
    idle(4);
    out_chk(K_AB, 8'h01, "R2 latch holds after pin returns");
    wr(BB + O_ACK, 8'hF7);
    out_chk(K_AB, 8'h01, "R3 zero bits leave latch");
    wr(BB + O_ACK, 8'h08);
    out_chk(K_AB, 8'h00, "R3 acknowledge clears latch");
    wr(BB + O_POL, 8'h00);
    idle(2);
    out_chk(K_AB, 8'h00, "R11 polarity change no event");
    set_pins(1, 8'h08);
    idle(4);
    out_chk(K_AB, 8'h00, "R2 rising ignored when falling selected");
    set_pins(1, 8'h00);
    idle(4);
    out_chk(K_AB, 8'h01, "R2 falling edge latched");
    wr(BB + O_ACK, 8'h08);
    out_chk(K_AB, 8'h00, "R3 acknowledge clears falling latch");
    wr(BB + O_EN, 8'h00);
    wr(BB + O_MODE, 8'h00);

    // R4 / R8: port F line 5 edge, enable gating
    wr(BF + O_MODE, 8'h20);
    wr(BF + O_POL,  8'h20);
    set_pins(2, 8'h20);
    idle(4);
    set_pins(2, 8'h00);
    idle(4);
    out_chk(K_F, 8'h00, "R4 edge while disabled ignored");
    wr(BF + O_EN, 8'h20);
    out_chk(K_F, 8'h00, "R4 no stale event on enable");
    set_pins(2, 8'h20);
    idle(4);
    out_chk(K_F,  8'h20, "R8 F line 5 own output");
    out_chk(K_AB, 8'h00, "R8 F does not reach shared line");
    wr(BF + O_EN, 8'h00);
    out_chk(K_F, 8'h00, "R4 disable drops status");
    wr(BF + O_EN, 8'h20);
    idle(2);
    out_chk(K_F, 8'h00, "R4 pending latch discarded");

    // R8: F level lines independent
    wr(BF + O_MODE, 8'h00);
    wr(BF + O_POL,  8'h81);
    wr(BF + O_EN,   8'h81);
    set_pins(2, 8'h81);
    idle(4);
    out_chk(K_F,  8'h81, "R8 F lines 0 and 7");
    out_chk(K_AB, 8'h00, "R8 shared line idle");
    set_pins(2, 8'h01);
    idle(4);
    out_chk(K_F, 8'h01, "R8 F line 7 alone drops");
    set_pins(2, 8'h00);
    wr(BF + O_EN, 8'h00);

    // R6: debounce on port A line 1
    wr(BA + O_MODE, 8'h00);
    wr(BA + O_POL,  8'h02);
    wr(BA + O_EN,   8'h02);
    wr(BA + O_DEB,  8'h02);
    out_chk(K_AB, 8'h00, "R6 debounced line idle");
    set_pins(0, 8'h02);
    idle(5);
    set_pins(0, 8'h00);
    idle(30);
    out_chk(K_AB, 8'h00, "R6 short pulse rejected");
    set_pins(0, 8'h02);
    idle(7);
    out_chk(K_AB, 8'h00, "R6 not yet accepted");
    idle(40);
    out_chk(K_AB, 8'h01, "R6 stable level accepted");
    rd_chk(BA + O_STAT, 8'h02, "R6 A status line 1");
    set_pins(0, 8'h00);
    idle(40);
    out_chk(K_AB, 8'h00, "R6 release accepted");

    idle(4);
    done = 1'b1;
    finish_run();
  end

endmodule